// File: doc/BRIEF.md
# SCSI Controller Status Register Block

This block is the host-visible register file of a small SCSI bus interface controller. A host reads and writes 16-bit registers at word-aligned byte offsets. Reads are combinational, so they complete with no wait states, and writes take effect on the clock edge. Two status registers track connection events and data-transfer events. Writing to them clears some flags with write-one-to-clear and leaves the hardware-owned fields as they were.

Each status register carries two summary flags, one for each event group. Both flags are mirrored into both registers, and together with an enable bit they drive a registered interrupt. A small command engine acts on the command register one cycle after the host writes it. It handles three commands: disconnect, select and a programmed-I/O byte transfer. The transfer is gated on phase bits and on the low bits of a free-running counter. The actual bus signalling, DMA movement, bus reset and arbitration are handled elsewhere.

Top module: `scsi_stat_regs`

## Requirements
- R1: Register byte offsets: diagnostic 0x00, control 0x0C, own ID 0x10, selector 0x14, detector status 0x18, data 0x20, DMA control 0x24, connection status 0x48, data status 0x4C, command 0x50, diagnostic control 0x54. All registers reset to zero. Reads of other offsets return zero, and writes to them are dropped. A write or read whose address has bits [1:0] non-zero is ignored, and such a read returns zero.
- R2: Connection status layout: 15 connection summary, 14 data summary, 13 reset seen, 12 state change, 11 bus error, 10 connected, 9 odd byte, 8 buffer, 7 lost data, 6:4 phase, 1 selection in progress. On a host write, a 1 in bit 13, 12, 11, 9, 8, 7 or 3 clears that bit. Bits under 0x3BF7 otherwise keep their old value, and every remaining bit takes the written value.
- R3: Data status layout: 15 and 14 the mirrored summaries, 13 done, 11 transmit empty, 10 input full, 4 mismatch, 2:0 counter. On a host write, a 1 in bit 13, 11, 10, 4 or 3 clears that bit. Bits under 0x0C17 otherwise keep their old value, and every remaining bit takes the written value.
- R4: The connection summary is the OR of bits 13, 12, 11, 9, 8 and 7 of connection status. The data summary is the OR of bits 13, 11, 10 and 4 of data status. Both summaries appear in bits 15 and 14 of both status registers, and host writes cannot set them.
- R5: `irq` is high exactly when control bit 0 is set and either summary is set. It is registered and follows the register state with no extra delay.
- R6: Own ID and selector keep only bits [2:0]. DMA control keeps bits [1:0], where 0 means asynchronous and any other value means synchronous. Data keeps bits [7:0]. The diagnostic and diagnostic-control registers keep all 16 bits. The detector status register ignores writes and reads zero.
- R7: Command bit 10 (disconnect) clears connected and selection-in-progress, then clears itself. It sets state change only if connected was set.
- R8: Command bit 8 (select) sets selection-in-progress, clears connected, and clears itself. If disconnect and select are both set, select acts last.
- R9: Command bit 7 (transfer) completes when all of these hold: bit 15 (DMA) is clear, command bits [6:4] equal connection status bits [6:4], command bits [1:0] equal the counter's low two bits after this cycle's tick, and selection-in-progress is clear. When it completes it clears bit 7 and sets transmit empty. Otherwise it stays pending.
- R10: Command bit 14 (reset request) is never stored.
- R11: Data status bits [2:0] advance by one, modulo 8, on every internal tick. With the default `TICK_DIV` of 1 there is one tick per clock.
- R12: A transfer with DMA bit 15 set stays pending and leaves data status unchanged.
- R13: A command acts on the clock edge after the edge that stores it, so its effect is visible one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a state-change event. It needs a live connection, and no command in scope makes one. The stimulus gets there by writing the host-writable connected bit into connection status and then issuing disconnect. The programmed-I/O transfer waits on a free-running counter. The bench therefore waits more than a full counter period before it checks the transfer. It also holds the transfer back with selection-in-progress, a phase mismatch and the DMA bit, and checks that it stays pending in each case.

// File: rtl/scsi_regs_pkg.sv
package scsi_regs_pkg;
  localparam int DW = 16;

  localparam int OFF_DIAG  = 'h00;
  localparam int OFF_CTRL  = 'h0C;
  localparam int OFF_ID    = 'h10;
  localparam int OFF_SLC   = 'h14;
  localparam int OFF_DET   = 'h18;
  localparam int OFF_DATA  = 'h20;
  localparam int OFF_DMAC  = 'h24;
  localparam int OFF_CSTAT = 'h48;
  localparam int OFF_DSTAT = 'h4C;
  localparam int OFF_COMM  = 'h50;
  localparam int OFF_DCTL  = 'h54;

  // connection status fields
  localparam int CS_CSUM = 15;
  localparam int CS_DSUM = 14;
  localparam int CS_SCH  = 12;
  localparam int CS_CON  = 10;
  localparam int CS_SIP  = 1;
  localparam logic [DW-1:0] CS_KEEP = 16'h3BF7;
  localparam logic [DW-1:0] CS_W1C  = 16'h3B88;
  localparam logic [DW-1:0] CS_SRC  = 16'h3B80;

  // data status fields
  localparam int DS_TBE = 11;
  localparam logic [DW-1:0] DS_KEEP = 16'h0C17;
  localparam logic [DW-1:0] DS_W1C  = 16'h2C18;
  localparam logic [DW-1:0] DS_SRC  = 16'h2C10;

  // command fields
  localparam int CM_DMA  = 15;
  localparam int CM_DISC = 10;
  localparam int CM_SEL  = 8;
  localparam int CM_XFER = 7;
  localparam logic [DW-1:0] CM_RSTRQ_M = 16'h4000;

  localparam int CTRL_IE = 0;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DIAG, SEL_CTRL, SEL_ID, SEL_SLC, SEL_DET, SEL_DATA,
    SEL_DMAC, SEL_CSTAT, SEL_DSTAT, SEL_COMM, SEL_DCTL
  } reg_sel_e;
endpackage

// File: rtl/scsi_reg_decode.sv
module scsi_reg_decode
  import scsi_regs_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  logic [ADDR_W-3:0] widx;
  assign widx = addr[ADDR_W-1:2];

  always_comb begin
    sel = SEL_NONE;
    if (addr[1:0] == 2'b00) begin
      case (int'(widx))
        OFF_DIAG/4:  sel = SEL_DIAG;
        OFF_CTRL/4:  sel = SEL_CTRL;
        OFF_ID/4:    sel = SEL_ID;
        OFF_SLC/4:   sel = SEL_SLC;
        OFF_DET/4:   sel = SEL_DET;
        OFF_DATA/4:  sel = SEL_DATA;
        OFF_DMAC/4:  sel = SEL_DMAC;
        OFF_CSTAT/4: sel = SEL_CSTAT;
        OFF_DSTAT/4: sel = SEL_DSTAT;
        OFF_COMM/4:  sel = SEL_COMM;
        OFF_DCTL/4:  sel = SEL_DCTL;
        default:     sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/scsi_tick_gen.sv
module scsi_tick_gen #(
  parameter int TICK_DIV = 1
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      logic unused_tick_inputs;
      assign unused_tick_inputs = clk ^ rst;
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(TICK_DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else if (cnt_q == CW'(TICK_DIV - 1)) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == CW'(TICK_DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/scsi_status_core.sv
module scsi_status_core
  import scsi_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_cstat,
  input  logic          wr_dstat,
  input  logic          wr_comm,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cstat_q,
  output logic [DW-1:0] dstat_q,
  output logic [DW-1:0] comm_q,
  output logic          sum_nx
);
  logic [DW-1:0] c_d, d_d, m_d;
  logic [2:0]    cnt_nx;
  logic          xfer_go, csum, dsum;

  always_comb begin
    c_d = cstat_q;
    if (wr_cstat)
      c_d = ((cstat_q & ~(wdata & CS_W1C)) & CS_KEEP) | (wdata & ~CS_W1C & ~CS_KEEP);
    d_d = dstat_q;
    if (wr_dstat)
      d_d = ((dstat_q & ~(wdata & DS_W1C)) & DS_KEEP) | (wdata & ~DS_W1C & ~DS_KEEP);
    cnt_nx = dstat_q[2:0] + {2'b00, tick};
    d_d[2:0] = cnt_nx;

    m_d = comm_q;
    if (comm_q[CM_DISC]) begin
      c_d[CS_CON] = 1'b0;
      c_d[CS_SIP] = 1'b0;
      if (cstat_q[CS_CON]) c_d[CS_SCH] = 1'b1;
      m_d[CM_DISC] = 1'b0;
    end
    if (comm_q[CM_SEL]) begin
      c_d[CS_SIP] = 1'b1;
      c_d[CS_CON] = 1'b0;
      m_d[CM_SEL] = 1'b0;
    end
    xfer_go = comm_q[CM_XFER] && !comm_q[CM_DMA]
           && (comm_q[6:4] == cstat_q[6:4])
           && (comm_q[1:0] == cnt_nx[1:0])
           && !c_d[CS_SIP];
    if (xfer_go) begin
      m_d[CM_XFER] = 1'b0;
      d_d[DS_TBE]  = 1'b1;
    end
    if (wr_comm) m_d = wdata & ~CM_RSTRQ_M;

    csum = |(c_d & CS_SRC);
    dsum = |(d_d & DS_SRC);
    c_d[CS_CSUM] = csum;
    c_d[CS_DSUM] = dsum;
    d_d[CS_CSUM] = csum;
    d_d[CS_DSUM] = dsum;
    sum_nx = csum | dsum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cstat_q <= '0;
      dstat_q <= '0;
      comm_q  <= '0;
    end else begin
      cstat_q <= c_d;
      dstat_q <= d_d;
      comm_q  <= m_d;
    end
  end

  assert_mirror_R4: assert property (@(posedge clk) disable iff (rst)
    cstat_q[15:14] == dstat_q[15:14]);
  assert_count_R11: assert property (@(posedge clk) disable iff (rst)
    tick |=> dstat_q[2:0] == $past(dstat_q[2:0]) + 3'd1);
  assert_norst_R10: assert property (@(posedge clk) disable iff (rst)
    !comm_q[14]);
  assert_select_R8: assert property (@(posedge clk) disable iff (rst)
    (comm_q[CM_SEL] && !wr_comm) |=> (cstat_q[CS_SIP] && !cstat_q[CS_CON] && !comm_q[CM_SEL]));
  assert_discon_R7: assert property (@(posedge clk) disable iff (rst)
    (comm_q[CM_DISC] && !comm_q[CM_SEL] && !wr_comm) |=> (!cstat_q[CS_CON] && !cstat_q[CS_SIP]));
  assert_blocked_R9: assert property (@(posedge clk) disable iff (rst)
    (comm_q[CM_XFER] && cstat_q[CS_SIP] && !comm_q[CM_DISC] && !wr_comm) |=> comm_q[CM_XFER]);
endmodule

// File: rtl/scsi_stat_regs.sv
module scsi_stat_regs
  import scsi_regs_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int TICK_DIV = 1,
  parameter int ID_W     = 3,
  parameter int DMAC_W   = 2,
  parameter int DATA_B   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              irq
);
  reg_sel_e sel;
  logic     wr, tick, sum_nx;
  logic [DW-1:0]     diag_q, ctrl_q, dctl_q, ctrl_d;
  logic [ID_W-1:0]   id_q, slc_q;
  logic [DMAC_W-1:0] dmac_q;
  logic [DATA_B-1:0] data_q;
  logic [DW-1:0]     cstat_q, dstat_q, comm_q;

  scsi_reg_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .sel(sel));
  scsi_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

  assign wr = bus_en && bus_we;

  scsi_status_core u_core (
    .clk(clk), .rst(rst), .tick(tick),
    .wr_cstat(wr && sel == SEL_CSTAT),
    .wr_dstat(wr && sel == SEL_DSTAT),
    .wr_comm (wr && sel == SEL_COMM),
    .wdata(bus_wdata),
    .cstat_q(cstat_q), .dstat_q(dstat_q), .comm_q(comm_q),
    .sum_nx(sum_nx)
  );

  assign ctrl_d = (wr && sel == SEL_CTRL) ? bus_wdata : ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      diag_q <= '0; ctrl_q <= '0; dctl_q <= '0;
      id_q <= '0; slc_q <= '0; dmac_q <= '0; data_q <= '0;
      irq <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      irq    <= ctrl_d[CTRL_IE] && sum_nx;
      if (wr) begin
        case (sel)
          SEL_DIAG: diag_q <= bus_wdata;
          SEL_DCTL: dctl_q <= bus_wdata;
          SEL_ID:   id_q   <= bus_wdata[ID_W-1:0];
          SEL_SLC:  slc_q  <= bus_wdata[ID_W-1:0];
          SEL_DMAC: dmac_q <= bus_wdata[DMAC_W-1:0];
          SEL_DATA: data_q <= bus_wdata[DATA_B-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_DIAG:  bus_rdata = diag_q;
      SEL_CTRL:  bus_rdata = ctrl_q;
      SEL_ID:    bus_rdata = DW'(id_q);
      SEL_SLC:   bus_rdata = DW'(slc_q);
      SEL_DATA:  bus_rdata = DW'(data_q);
      SEL_DMAC:  bus_rdata = DW'(dmac_q);
      SEL_CSTAT: bus_rdata = cstat_q;
      SEL_DSTAT: bus_rdata = dstat_q;
      SEL_COMM:  bus_rdata = comm_q;
      SEL_DCTL:  bus_rdata = dctl_q;
      default:   bus_rdata = '0;
    endcase
  end

  assert_irq_R5: assert property (@(posedge clk) disable iff (rst)
    irq == (ctrl_q[CTRL_IE] && (cstat_q[15] || dstat_q[14])));
  assert_unaligned_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_scsi_stat_regs.sv
module tb_scsi_stat_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1, bus_en = 1'b0, bus_we = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  scsi_stat_regs dut (.clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_en = 1'b1; bus_we = 1'b1;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic rd_now(input logic [6:0] a, output logic [15:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, a0, a1;
    idle(3);
    rst = 1'b0;

    // R1 reset values
    begin
      int offs[10] = '{'h00, 'h0C, 'h10, 'h14, 'h18, 'h20, 'h24, 'h48, 'h50, 'h54};
      for (int i = 0; i < 10; i++) begin
        rd(7'(offs[i]), v); chk("R1 reset", v, 16'h0);
      end
    end
    rd(7'h4C, v); chk("R1 reset dstat", v & 16'hFFF8, 16'h0);
    chk("R5 reset irq", {15'b0, irq}, 16'h0);

    // R1 unaligned and unmapped
    wr(7'h0D, 16'hFFFF);
    rd(7'h0C, v); chk("R1 unaligned write", v, 16'h0);
    wr(7'h0C, 16'h00F0);
    rd(7'h0E, v); chk("R1 unaligned read", v, 16'h0);
    wr(7'h30, 16'h1234);
    rd(7'h30, v); chk("R1 unmapped", v, 16'h0);
    wr(7'h0C, 16'h0000);

    // R6 sweep of plain registers
    for (int k = 0; k < 16; k++) begin
      logic [15:0] p;
      p = 16'(k) * 16'h1111 ^ 16'hA5C3;
      wr(7'h10, p); rd(7'h10, v); chk("R6 id", v, p & 16'h0007);
      wr(7'h14, p); rd(7'h14, v); chk("R6 selector", v, p & 16'h0007);
      wr(7'h24, p); rd(7'h24, v); chk("R6 dma ctrl", v, p & 16'h0003);
      wr(7'h20, p); rd(7'h20, v); chk("R6 data", v, p & 16'h00FF);
      wr(7'h00, p); rd(7'h00, v); chk("R6 diag", v, p);
      wr(7'h54, p); rd(7'h54, v); chk("R6 diag ctrl", v, p);
      wr(7'h18, p); rd(7'h18, v); chk("R6 detector", v, 16'h0);
    end

    // R11 counter
    rd(7'h4C, a0); idle(4); rd(7'h4C, a1);
    chk("R11 counter", {13'b0, a1[2:0]}, {13'b0, 3'(a0[2:0] + 3'd5)});

    // R2 write all ones: only writable bits (connected) take it
    wr(7'h48, 16'hFFFF);
    rd(7'h48, v); chk("R2 cstat write", v, 16'h0400);

    // R7 disconnect with connection
    wr(7'h50, 16'h0400);
    rd(7'h48, v); chk("R7 state change", v, 16'h9000);
    rd(7'h4C, v); chk("R4 mirror", v & 16'hFFF8, 16'h8000);
    rd(7'h50, v); chk("R7 self clear", v, 16'h0);
    chk("R5 irq disabled", {15'b0, irq}, 16'h0);
    wr(7'h0C, 16'h0001);
    chk("R5 irq enabled", {15'b0, irq}, 16'h1);

    // R2 keep and clear
    wr(7'h48, 16'h0000);
    rd(7'h48, v); chk("R2 keep", v, 16'h9000);
    wr(7'h48, 16'h1000);
    rd(7'h48, v); chk("R2 w1c", v, 16'h0000);
    chk("R5 irq drop", {15'b0, irq}, 16'h0);

    // R13 and R8 select timing
    wr(7'h50, 16'h0100);
    rd_now(7'h48, v); chk("R13 not yet", v, 16'h0000);
    rd(7'h48, v); chk("R8 select", v, 16'h0002);
    rd(7'h50, v); chk("R8 self clear", v, 16'h0);

    // R9 blocked by selection in progress
    wr(7'h50, 16'h0080);
    idle(12);
    rd(7'h50, v); chk("R9 blocked sip", v, 16'h0080);
    rd(7'h4C, v); chk("R9 no tbe", v & 16'hFFF8, 16'h0);

    // R7 no state change without connection, R9 transfer completes
    wr(7'h50, 16'h0480);
    idle(12);
    rd(7'h50, v); chk("R9 done", v, 16'h0);
    rd(7'h48, v); chk("R7 no sch", v, 16'h4000);
    rd(7'h4C, v); chk("R9 tbe", v & 16'hFFF8, 16'h4800);
    chk("R5 irq data", {15'b0, irq}, 16'h1);

    // R3 data status writes
    wr(7'h4C, 16'h0000);
    rd(7'h4C, v); chk("R3 keep", v & 16'hFFF8, 16'h4800);
    wr(7'h4C, 16'hFFFF);
    rd(7'h4C, v); chk("R3 w1c", v & 16'hFFF8, 16'h13E0);
    rd(7'h48, v); chk("R4 summary clear", v, 16'h0000);
    wr(7'h4C, 16'h0000);
    rd(7'h4C, v); chk("R3 plain", v & 16'hFFF8, 16'h0);

    // R9 phase mismatch
    wr(7'h50, 16'h0090);
    idle(12);
    rd(7'h50, v); chk("R9 phase", v, 16'h0090);

    // R12 DMA flagged
    wr(7'h50, 16'h8080);
    idle(12);
    rd(7'h50, v); chk("R12 pending", v, 16'h8080);
    rd(7'h4C, v); chk("R12 no tbe", v & 16'hFFF8, 16'h0);

    // R10 reset request
    wr(7'h50, 16'h4000);
    rd(7'h50, v); chk("R10 not stored", v, 16'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule